// File: doc/BRIEF.md
# Byte-Interleaved DMA Bus Arbiter

This block decides who owns a shared microprocessor bus: the processor or one of seven DMA request channels. A DMA grant covers exactly one byte. When that byte completes, the bus returns to the processor for one bus cycle before any other DMA grant is made. Every DMA grant is chosen from the requests present at the moment the processor's cycle ends. A channel that holds its request asserted therefore cannot keep the bus across transfers.

Channels use a fixed priority, and channel 0 is the highest. The two lowest channels, 5 and 6, carry traffic from memory to the cipher engine and from the cipher engine to memory. These two request almost all the time. They rank above the processor but below every other channel, and re-arbitration after each byte keeps them from starving the channels above them. Any channel may be wired to a cascaded second DMA controller, which the arbiter handles like any other channel. A single `done_i` pulse marks the end of the current bus cycle, whether the processor or a channel owns the bus.

Top module: `dma_single_arbiter`

## Requirements
- R1: After reset, `cpu_grant_o` is 1 and `ack_o` is all zeros.
- R2: In every cycle exactly one owner holds the bus. Either `cpu_grant_o` is 1 and `ack_o` is zero, or `cpu_grant_o` is 0 and `ack_o` has exactly one bit set. Bit i of `ack_o` acknowledges channel i.
- R3: While no channel requests, the processor keeps the bus, and `done_i` pulses have no effect.
- R4: Suppose the processor owns the bus, `done_i` is high and at least one request bit is set. In the next cycle `ack_o` has only the lowest-numbered requesting channel set, because channel 0 has the highest priority.
- R5: Once a channel has been acknowledged, `ack_o` does not change until a cycle in which `done_i` is high.
- R6: After `done_i` ends a DMA transfer, the next cycle gives the bus to the processor. Two DMA grants never follow each other directly.
- R7: Suppose the processor owns the bus and `done_i` is low. The processor keeps the bus whatever the request lines do.
- R8: A channel's acknowledge stays asserted until `done_i`, even if that channel drops its request during the transfer.
- R9: The cipher channels (indices 5 and 6) are acknowledged only when no channel 0 to 4 requests at the decision edge. If the cipher channels request without pause, a higher channel that raises its request is served in the next DMA slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 7 | DMA request per channel, bit 0 highest priority |
| done_i | input | 1 | One-cycle pulse ending the current bus cycle |
| ack_o | output | 7 | One-hot DMA acknowledge |
| cpu_grant_o | output | 1 | Processor owns the bus |

## Verification
The assertions assume that `done_i` is a pulse of one clock wide for each bus cycle and that request lines change only between clock edges. They make no assumption about how requests relate to acknowledges. The stimulus drives every input on the falling edge and pulses `done_i` for exactly one cycle. It walks through all 128 request patterns, and in each one it drops requests in the middle of the transfer. It also holds both cipher channels high without pause while higher channels come and go.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic {
    OWN_CPU = 1'b0,
    OWN_DMA = 1'b1
  } owner_e;
endpackage

// File: rtl/dma_arb_prio.sv
module dma_arb_prio #(
  parameter int unsigned N_CH = 7
) (
  input  logic [N_CH-1:0] req_i,
  output logic [N_CH-1:0] gnt_o
);
  logic [N_CH:0] blk;

  assign blk[0] = 1'b0;
  for (genvar i = 0; i < N_CH; i++) begin : g_chain
    assign blk[i+1]  = blk[i] | req_i[i];
    assign gnt_o[i]  = req_i[i] & ~blk[i];
  end

  // R4: the encoder output carries at most one bit
  always_comb begin
    assert_prio_onehot_R4: assert ($onehot0(gnt_o));
  end
endmodule

// File: rtl/dma_arb_slot.sv
module dma_arb_slot
  import dma_arb_pkg::*;
#(
  parameter int unsigned N_CH     = 7,
  parameter int unsigned N_CIPHER = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] req_i,
  input  logic [N_CH-1:0] win_i,
  input  logic            done_i,
  output logic [N_CH-1:0] ack_o,
  output logic            cpu_grant_o
);
  localparam int unsigned CIPHER_BASE = N_CH - N_CIPHER;

  owner_e          owner_q;
  logic [N_CH-1:0] ack_q;
  logic            pending;

  assign pending = |req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q <= OWN_CPU;
      ack_q   <= '0;
    end else if (done_i) begin
      if (owner_q == OWN_DMA) begin
        owner_q <= OWN_CPU;   // forced processor cycle between bytes
        ack_q   <= '0;
      end else if (pending) begin
        owner_q <= OWN_DMA;
        ack_q   <= win_i;
      end
    end
  end

  assign ack_o       = ack_q;
  assign cpu_grant_o = (owner_q == OWN_CPU);

  assert_one_owner_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_o) && (cpu_grant_o ^ (ack_o != '0)));

  assert_grant_requested_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_grant_o && done_i && req_i != '0) |=> ((ack_o & $past(req_i)) != '0));

  assert_ack_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o != '0 && !done_i) |=> $stable(ack_o));

  assert_cpu_after_dma_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o != '0 && done_i) |=> cpu_grant_o);

  assert_cpu_keeps_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_grant_o && (!done_i || req_i == '0)) |=> cpu_grant_o);

  assert_cipher_yield_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_grant_o && done_i && req_i[CIPHER_BASE-1:0] != '0)
      |=> (ack_o[N_CH-1:CIPHER_BASE] == '0));
endmodule

// File: rtl/dma_single_arbiter.sv
module dma_single_arbiter #(
  parameter int unsigned N_CH     = 7,
  parameter int unsigned N_CIPHER = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] req_i,
  input  logic            done_i,
  output logic [N_CH-1:0] ack_o,
  output logic            cpu_grant_o
);
  logic [N_CH-1:0] win;

  dma_arb_prio #(.N_CH(N_CH)) u_prio (
    .req_i (req_i),
    .gnt_o (win)
  );

  dma_arb_slot #(.N_CH(N_CH), .N_CIPHER(N_CIPHER)) u_slot (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .win_i       (win),
    .done_i      (done_i),
    .ack_o       (ack_o),
    .cpu_grant_o (cpu_grant_o)
  );
endmodule

// File: tb/dma_single_arbiter_tb.sv
`timescale 1ns/1ps
module dma_single_arbiter_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [6:0] req = '0;
  logic       done = 1'b0;
  logic [6:0] ack;
  logic       cpu_grant;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dma_single_arbiter u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .done_i(done),
    .ack_o(ack), .cpu_grant_o(cpu_grant)
  );

  task automatic chk(input string tag, input logic [7:0] exp);
    logic [7:0] act;
    act = {cpu_grant, ack};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h req=%07b", tag, act, exp, req);
    end
  endtask

  task automatic pulse_done();
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", 8'h80);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 after release", 8'h80);

    // R3: idle bus with done pulses
    for (int k = 0; k < 3; k++) begin
      pulse_done();
      chk("R3 idle", 8'h80);
    end

    // R7: requests without done leave the processor on the bus
    req = 7'h7f;
    repeat (3) @(negedge clk);
    chk("R7 no done", 8'h80);

    // exhaustive request sweep
    for (int p = 0; p < 128; p++) begin
      logic [6:0] pv, low;
      pv  = p[6:0];
      low = pv & (~pv + 7'd1);
      req = pv;
      pulse_done();
      if (pv == 0) begin
        chk("R3 no request", 8'h80);
      end else begin
        chk((pv[4:0] != 0 && pv[6:5] != 0) ? "R9 priority" : "R4 priority", {1'b0, low});
        @(negedge clk);
        @(negedge clk);
        chk("R5 hold", {1'b0, low});
        req = '0;
        @(negedge clk);
        chk("R8 drop", {1'b0, low});
        req = pv;
        pulse_done();
        chk("R6 cpu slot", 8'h80);
        req = '0;
        pulse_done();
        chk("R7 stay cpu", 8'h80);
      end
    end

    // R9: cipher channels always requesting
    req = 7'b1100000;
    pulse_done();
    chk("R9 cipher served", 8'h20);
    req[2] = 1'b1;
    pulse_done();
    chk("R6 cpu slot", 8'h80);
    pulse_done();
    chk("R9 ch2 preempts", 8'h04);
    req[2] = 1'b0;
    req[0] = 1'b1;
    pulse_done();
    chk("R6 cpu slot", 8'h80);
    pulse_done();
    chk("R9 ch0 preempts", 8'h01);
    req[0] = 1'b0;
    pulse_done();
    pulse_done();
    chk("R9 cipher back", 8'h20);
    pulse_done();
    req = 7'b1000000;
    pulse_done();
    chk("R9 ch6 alone", 8'h40);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule